// File: doc/BRIEF.md
# Maskable Interrupt Latch Controller

This block collects five peripheral interrupt sources (synchronous serial, asynchronous serial, a tempo timer, a sample timer and an external pin) into a single interrupt request line. Each source has its own pending latch, set on a rising edge of the source's level input. Each source also has its own enable bit. The request line is asserted while at least one source is both pending and enabled.

Software reaches the block through one 16-bit register. A single write updates the enables, which sit in the low byte, and clears pending latches, which sit in the high byte. A 1 written to a clear bit empties that source's latch, and a 0 leaves it alone. A read returns the pending latches and the enables from the same positions. Priority encoding and vectoring are done elsewhere.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset, all pending latches and all enables are 0, `reg_rdata` reads 0x0000 and `irq_req` is 0.
- R2: A write (`reg_wr`=1) loads `reg_wdata[4:0]` into the enables, which read back on `reg_rdata[4:0]`. Bit 4 enables synchronous serial, bit 3 asynchronous serial, bit 2 the tempo timer, bit 1 the sample timer and bit 0 the external source.
- R3: `reg_rdata[12:8]` returns the pending latches, with source order matching the enables: bit 12 synchronous serial down to bit 8 external. All other read bits are 0.
- R4: A 0-to-1 transition on `src_lvl[i]` sets pending latch i at the clock edge where the high level is first sampled, whether or not source i is enabled. A level that stays high does not set the latch again. `src_lvl` index i maps to the same source as enable bit i.
- R5: A write with `reg_wdata[8+i]`=1 clears pending latch i at that edge. A 0 in a clear bit leaves the latch unchanged.
- R6: If a clear of latch i and a rising event on source i fall on the same edge, the latch is set after that edge.
- R7: `irq_req` is registered. After each edge it equals the OR over all sources of (pending AND enable), as that state held just before the edge, so it follows the latches one cycle later.
- R8: Writes to bits 15:13 and 7:5 are ignored. Those bits read 0 and leave the latches unchanged.
- R9: A single write that sets enables and clears latches applies both at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lvl | input | 5 | Source levels; rising edge raises the event (4 sync serial .. 0 external) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Write data: 12:8 clear-on-one, 4:0 enables |
| reg_rdata | output | 16 | Read data: 12:8 pending, 4:0 enables |
| irq_req | output | 1 | Registered interrupt request |

## Verification
The bench raises a source while its enable is off, to confirm that latching does not depend on the enable. It clears a latch while the source level is still held high. A design that treats the source as level-sensitive would set the latch again and would fail that check. It writes clear and enable together with an event landing on the same edge, which catches a design that lets the clear win or that drops one half of a combined write. It writes ones to the unimplemented bits and checks that they read back 0, and it samples `irq_req` both one edge and two edges after a change, which exposes a request line that is combinational or delayed by an extra stage.

// File: rtl/irq_latch_pkg.sv
// Package: shared sizes and field positions of the interrupt latch register.
// Assumes one register; clear and enable fields hold the same source order.
package irq_latch_pkg;
    localparam int NUM_SRC = 5;
    localparam int REG_W   = 16;
    localparam int EN_LSB  = 0;
    localparam int CLR_LSB = 8;

    // Source index shared by src_lvl, the enable field and the clear field.
    typedef enum logic [2:0] {
        SRC_EXT    = 3'd0,
        SRC_SAMPLE = 3'd1,
        SRC_TEMPO  = 3'd2,
        SRC_ASYNC  = 3'd3,
        SRC_SYNC   = 3'd4
    } src_id_e;
endpackage

// File: rtl/irq_edge_detect.sv
// Module: rising-edge detector across a vector of source levels.
// Assumes levels are already synchronous to clk; the history resets low.
module irq_edge_detect #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] lvl_q;

    // Keep last cycle's levels to compare against.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    // An event is a level high now and low one cycle earlier.
    always_comb rise = lvl & ~lvl_q;

    // R4: an event cannot repeat on consecutive cycles.
    p_single_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/irq_pend_cell.sv
// Module: one source's pending latch.
// Set by an event, cleared by a write-one; the event wins a same-edge tie.
module irq_pend_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic pend
);
    // Update the latch: the set has priority over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend <= 1'b0;
        else if (set_evt) pend <= 1'b1;
        else if (clr_req) pend <= 1'b0;
    end

    // R4 / R6: an event always leaves the latch set.
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> pend);
    // R5: a clear with no event empties the latch.
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_evt) |=> !pend);
    // R5: with neither a set nor a clear, the latch holds.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_req && !set_evt) |=> $stable(pend));
endmodule

// File: rtl/irq_latch_ctrl.sv
// Module: top of the maskable interrupt latch controller.
// One 16-bit register: 12:8 write-one-to-clear / read pending, 4:0 enables.
// Assumes source levels and the write strobe are synchronous to clk.
module irq_latch_ctrl
    import irq_latch_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int DW    = REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_lvl,
    input  logic             reg_wr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             irq_req
);
    localparam int EN_MSB  = EN_LSB + N_SRC - 1;
    localparam int CLR_MSB = CLR_LSB + N_SRC - 1;

    logic [N_SRC-1:0] rise;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] clr_vec;
    logic             req_next;

    irq_edge_detect #(.W(N_SRC)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (src_lvl),
        .rise  (rise)
    );

    // Clear requests exist only on a write cycle.
    always_comb clr_vec = reg_wr ? reg_wdata[CLR_MSB:CLR_LSB] : '0;

    for (genvar i = 0; i < N_SRC; i++) begin : g_cell
        irq_pend_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (rise[i]),
            .clr_req (clr_vec[i]),
            .pend    (pend[i])
        );
    end

    // Enable register, loaded on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (reg_wr) en_q <= reg_wdata[EN_MSB:EN_LSB];
    end

    // Any source both pending and enabled asks for service.
    always_comb req_next = |(pend & en_q);

    // Registered request output.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_req <= 1'b0;
        else        irq_req <= req_next;
    end

    // Read path: pending in the clear field, enables in the enable field.
    always_comb begin
        reg_rdata                   = '0;
        reg_rdata[CLR_MSB:CLR_LSB]  = pend;
        reg_rdata[EN_MSB:EN_LSB]    = en_q;
    end

    // R2: a write shows up in the enables at the next cycle.
    p_en_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata[EN_MSB:EN_LSB] == $past(reg_wdata[EN_MSB:EN_LSB])));
    // R7: a pending enabled source raises the request one edge later.
    p_req_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(reg_rdata[CLR_MSB:CLR_LSB] & reg_rdata[EN_MSB:EN_LSB])) |=> irq_req);
    // R7: with nothing pending and enabled, the request drops one edge later.
    p_req_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(reg_rdata[CLR_MSB:CLR_LSB] & reg_rdata[EN_MSB:EN_LSB])) |=> !irq_req);
    // R1: reset empties all state.
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (reg_rdata == '0 && !irq_req));
endmodule

// File: tb/tb_irq_latch_ctrl.sv
module tb_irq_latch_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_lvl = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    irq_latch_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Each vector: {wr, wdata[15:0], src[4:0], exp_rdata[15:0], exp_irq}
    localparam int NV = 8;
    localparam logic [38:0] VEC [NV] = '{
        {1'b1, 16'h001F, 5'h00, 16'h001F, 1'b0}, // R2 all enables
        {1'b0, 16'h0000, 5'h01, 16'h011F, 1'b1}, // R4 R7 external event
        {1'b1, 16'h0100, 5'h01, 16'h0000, 1'b0}, // R5 clear, level held
        {1'b0, 16'h0000, 5'h1E, 16'h1E00, 1'b0}, // R4 latch while disabled
        {1'b1, 16'h0004, 5'h1E, 16'h1E04, 1'b1}, // R7 enable tempo
        {1'b1, 16'hE0E0, 5'h1E, 16'h1E00, 1'b0}, // R8 unused bits ignored
        {1'b1, 16'h0A11, 5'h1E, 16'h1411, 1'b1}, // R9 clear and enable together
        {1'b1, 16'h1F00, 5'h00, 16'h0000, 1'b0}  // R5 clear all
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) tick();
        check("R1 rdata", reg_rdata, 16'h0000);
        check("R1 irq", {15'b0, irq_req}, 16'h0000);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            reg_wr    = VEC[v][38];
            reg_wdata = VEC[v][37:22];
            src_lvl   = VEC[v][21:17];
            tick();
            reg_wr = 1'b0;
            tick();
            check($sformatf("R3 vec%0d rdata", v), reg_rdata, VEC[v][16:1]);
            check($sformatf("R7 vec%0d irq", v), {15'b0, irq_req}, {15'b0, VEC[v][0]});
        end

        // R6: clear and rising event on the sample timer at the same edge.
        reg_wr = 1'b1; reg_wdata = 16'h0202; src_lvl = 5'h02;
        tick();
        reg_wr = 1'b0;
        check("R6 event beats clear", reg_rdata, 16'h0202);
        check("R7 request lags one edge", {15'b0, irq_req}, 16'h0000);
        tick();
        check("R7 request after lag", {15'b0, irq_req}, 16'h0001);

        // R5: a zero clear bit leaves the latch alone.
        reg_wr = 1'b1; reg_wdata = 16'h0002;
        tick();
        reg_wr = 1'b0;
        check("R5 zero clear keeps latch", reg_rdata, 16'h0202);

        // R1: reset in mid-run empties everything.
        rst_n = 1'b0;
        tick();
        check("R1 reset rdata", reg_rdata, 16'h0000);
        check("R1 reset irq", {15'b0, irq_req}, 16'h0000);
        src_lvl = '0;
        rst_n = 1'b1;
        tick();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule